// File: doc/BRIEF.md
# I2C Dual Slave Address Matcher

This block is the receiving front end of an I2C target device. It oversamples SCL and SDA against the system clock and detects START, repeated START and STOP conditions. It shifts in the address byte that follows each START and compares it against two programmable slave addresses. Each slave address has its own don't-care mask and its own choice of 7-bit or 10-bit addressing. When an address matches, the block pulls SDA low during the ninth clock. It then reports which address hit and the direction bit, and gives a one-cycle wake indication.

For 10-bit addressing, the block first acknowledges a header byte whose upper five bits are 11110. It then compares the second byte against the lower eight address bits. After a 10-bit write has matched, a repeated START followed by a read header alone re-addresses the same device, without a second byte. When no address matches, the block stays off the bus until the next START. A separate time-out counter watches for SCL being held low too long. Data-phase handling, master operation and arbitration belong to neighbouring logic.

Top module: `i2c_addr_match`

## Requirements
- R1: `start_o` pulses for one cycle when SDA falls while SCL is high. `rstart_o` pulses with it when no STOP has been seen since the previous START. `stop_o` pulses when SDA rises while SCL is high.
- R2: The first byte after a START is taken MSB first on SCL rising edges. Its bits [7:1] are the 7-bit address and bit 0 is R/W (1 = read). A match against a slot with its 10-bit select at 0 drives `sda_oe_o` high from the falling edge after the eighth bit until the falling edge of the ninth clock. After that match, `addressed_o`=1, `hit_id_o` gives the slot and `hit_rw_o` gives the R/W bit.
- R3: An address bit whose mask bit is 1 is left out of the comparison.
- R4: When both slots match, slot 0 is reported (`hit_id_o`=0).
- R5: A first byte of the form 11110,A9,A8,RW is acknowledged when a slot in 10-bit mode matches A9:A8 under its mask. The second byte is then compared against that slot's bits [7:0]. A match acknowledges the second byte and reports the slot, with R/W taken from the header.
- R6: If the second byte of a 10-bit address does not match, it is not acknowledged and `addressed_o` stays 0.
- R7: When the address does not match, `sda_oe_o` stays 0 for every later byte until the next START, even if such a byte carries a matching address.
- R8: After a 10-bit address has matched and before any STOP, a repeated START followed by a read header (RW=1) whose A9:A8 fit the matched slot is acknowledged. It reports that slot with `hit_rw_o`=1, without a second byte.
- R9: `wake_o` pulses for exactly one cycle for every completed address match and at no other time.
- R10: The time-out counter advances once every `cfg_tick_div`+1 cycles while SCL is low and restarts on every SCL edge. When the count reaches `cfg_tmo_limit` (non-zero), `tmo_o` is set and stays set until `tmo_clr_i`.
- R11: A STOP clears `addressed_o`.
- R12: After reset, `sda_oe_o`, `addressed_o` and `tmo_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe_o | output | 1 | 1 pulls SDA low (acknowledge) |
| cfg_addr0 | input | 10 | Slot 0 address (7-bit mode uses [6:0]) |
| cfg_mask0 | input | 10 | Slot 0 don't-care mask, 1 = ignore bit |
| cfg_ten0 | input | 1 | Slot 0 uses 10-bit addressing |
| cfg_addr1 | input | 10 | Slot 1 address |
| cfg_mask1 | input | 10 | Slot 1 don't-care mask |
| cfg_ten1 | input | 1 | Slot 1 uses 10-bit addressing |
| cfg_tick_div | input | PRE_W | Time-out tick period minus one, in cycles |
| cfg_tmo_limit | input | TMO_W | Time-out limit in ticks (0 disables) |
| tmo_clr_i | input | 1 | Clears the time-out flag |
| start_o | output | 1 | START detected pulse |
| rstart_o | output | 1 | Repeated START detected pulse |
| stop_o | output | 1 | STOP detected pulse |
| addressed_o | output | 1 | Device currently addressed |
| hit_id_o | output | 1 | Slot that matched |
| hit_rw_o | output | 1 | R/W bit of the matched transfer |
| wake_o | output | 1 | One-cycle pulse on address match |
| tmo_o | output | 1 | Sticky bus time-out flag |

## Verification
The bench uses two synchronizer stages, a 4-bit prescaler and the 10-bit time-out counter. It runs the bus with eight-cycle phases and sets a tick divider of 1 with a limit of 20 ticks. Ordinary SCL low phases then stay well under the limit, while a held-low SCL crosses the limit within a few dozen cycles. This puts both the restart-on-edge behaviour and the sticky flag within reach of short directed runs. The two slots are reconfigured between phases to cover 7-bit masking, double-match priority, and the 10-bit header, second byte and repeated-START read paths.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;

    localparam int unsigned ADDR_W = 10;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned BITC_W = 4;
    localparam logic [4:0]  TEN_HDR = 5'b11110;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK,
        ST_ADDR2,
        ST_HOLD,
        ST_SKIP
    } am_state_e;

endpackage

// File: rtl/i2c_am_cond.sv
module i2c_am_cond #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl_o,
    output logic sda_lvl_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic rstart_o,
    output logic stop_o
);

    localparam int unsigned SW = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

    typedef struct packed {
        logic [SW-1:0] scl_sh;
        logic [SW-1:0] sda_sh;
        logic          scl_p;
        logic          sda_p;
        logic          busy;
    } cond_t;

    cond_t d, q;
    logic  scl_s, sda_s;

    always_comb begin
        d      = q;
        scl_s  = q.scl_sh[SW-1];
        sda_s  = q.sda_sh[SW-1];
        d.scl_sh = {q.scl_sh[SW-2:0], scl_i};
        d.sda_sh = {q.sda_sh[SW-2:0], sda_i};
        d.scl_p  = scl_s;
        d.sda_p  = sda_s;

        start_o    = scl_s & q.scl_p & q.sda_p & ~sda_s;
        stop_o     = scl_s & q.scl_p & ~q.sda_p & sda_s;
        scl_rise_o = scl_s & ~q.scl_p;
        scl_fall_o = ~scl_s & q.scl_p;
        rstart_o   = start_o & q.busy;

        if (stop_o)       d.busy = 1'b0;
        else if (start_o) d.busy = 1'b1;

        scl_lvl_o = scl_s;
        sda_lvl_o = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.scl_sh <= '1;
            q.sda_sh <= '1;
            q.scl_p  <= 1'b1;
            q.sda_p  <= 1'b1;
            q.busy   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    // R1
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> q.busy);

    // R1
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o |=> (!q.busy && !rstart_o));

endmodule

// File: rtl/i2c_am_tmo.sv
module i2c_am_tmo #(
    parameter int unsigned PRE_W = 8,
    parameter int unsigned TMO_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_lvl_i,
    input  logic             scl_edge_i,
    input  logic [PRE_W-1:0] div_i,
    input  logic [TMO_W-1:0] limit_i,
    input  logic             clr_i,
    output logic             flag_o
);

    localparam logic [TMO_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [TMO_W-1:0] cnt;
        logic             flag;
    } tmo_t;

    tmo_t d, q;
    logic tick;

    always_comb begin
        d    = q;
        tick = (q.pre == div_i);
        if (scl_edge_i || scl_lvl_i) begin
            d.pre = '0;
            d.cnt = '0;
        end else if (tick) begin
            d.pre = '0;
            if (q.cnt != CNT_MAX) d.cnt = q.cnt + 1'b1;
        end else begin
            d.pre = q.pre + 1'b1;
        end

        if (clr_i)
            d.flag = 1'b0;
        else if ((limit_i != '0) && !scl_lvl_i && (q.cnt >= limit_i))
            d.flag = 1'b1;

        flag_o = q.flag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R10
    tmo_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.flag && !clr_i) |=> q.flag);

    // R10
    tmo_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scl_edge_i |=> (q.cnt == '0));

endmodule

// File: rtl/i2c_am_ctrl.sv
module i2c_am_ctrl
    import i2c_am_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic              sda_i,
    input  logic [ADDR_W-1:0] addr0_i,
    input  logic [ADDR_W-1:0] mask0_i,
    input  logic              ten0_i,
    input  logic [ADDR_W-1:0] addr1_i,
    input  logic [ADDR_W-1:0] mask1_i,
    input  logic              ten1_i,
    output logic              sda_oe_o,
    output logic              hit_o,
    output logic              hit_id_o,
    output logic              hit_rw_o,
    output logic              wake_o
);

    typedef struct packed {
        am_state_e         st;
        logic [BYTE_W-1:0] sh;
        logic [BITC_W-1:0] cnt;
        logic [1:0]        cand;
        logic              next2;
        logic              rw;
        logic              hit;
        logic              id;
        logic              oe;
        logic              wake;
        logic              mem_vld;
        logic              mem_id;
    } ctrl_t;

    ctrl_t d, q;

    function automatic logic fit7(input logic [BYTE_W-1:0] b,
                                  input logic [ADDR_W-1:0] a,
                                  input logic [ADDR_W-1:0] m);
        return ((b[7:1] ^ a[6:0]) & ~m[6:0]) == 7'd0;
    endfunction

    function automatic logic fit_hi(input logic [BYTE_W-1:0] b,
                                    input logic [ADDR_W-1:0] a,
                                    input logic [ADDR_W-1:0] m);
        return ((b[2:1] ^ a[9:8]) & ~m[9:8]) == 2'd0;
    endfunction

    function automatic logic fit_lo(input logic [BYTE_W-1:0] b,
                                    input logic [ADDR_W-1:0] a,
                                    input logic [ADDR_W-1:0] m);
        return ((b ^ a[7:0]) & ~m[7:0]) == 8'd0;
    endfunction

    logic       hdr, mem_ok, byte_done;
    logic [1:0] c7, chi, clo;

    always_comb begin
        d      = q;
        d.wake = 1'b0;

        byte_done = fall_i && (q.cnt == 4'd8);
        hdr    = (q.sh[7:3] == TEN_HDR);
        c7[0]  = !ten0_i && fit7(q.sh, addr0_i, mask0_i);
        c7[1]  = !ten1_i && fit7(q.sh, addr1_i, mask1_i);
        chi[0] = ten0_i && fit_hi(q.sh, addr0_i, mask0_i);
        chi[1] = ten1_i && fit_hi(q.sh, addr1_i, mask1_i);
        clo[0] = q.cand[0] && fit_lo(q.sh, addr0_i, mask0_i);
        clo[1] = q.cand[1] && fit_lo(q.sh, addr1_i, mask1_i);
        mem_ok = q.mem_vld && q.sh[0] &&
                 (q.mem_id ? fit_hi(q.sh, addr1_i, mask1_i)
                           : fit_hi(q.sh, addr0_i, mask0_i));

        if (stop_i) begin
            d.st      = ST_IDLE;
            d.oe      = 1'b0;
            d.hit     = 1'b0;
            d.mem_vld = 1'b0;
            d.cnt     = '0;
        end else if (start_i) begin
            d.st   = ST_ADDR;
            d.cnt  = '0;
            d.oe   = 1'b0;
            d.hit  = 1'b0;
            d.cand = '0;
        end else begin
            case (q.st)
                ST_ADDR, ST_ADDR2: begin
                    if (rise_i) begin
                        d.sh  = {q.sh[BYTE_W-2:0], sda_i};
                        d.cnt = q.cnt + 1'b1;
                    end else if (byte_done) begin
                        d.cnt = '0;
                        if (q.st == ST_ADDR) begin
                            d.rw = q.sh[0];
                            if (hdr) begin
                                if (mem_ok) begin
                                    d.hit   = 1'b1;
                                    d.id    = q.mem_id;
                                    d.wake  = 1'b1;
                                    d.oe    = 1'b1;
                                    d.next2 = 1'b0;
                                    d.st    = ST_ACK;
                                end else if (|chi) begin
                                    d.cand    = chi;
                                    d.oe      = 1'b1;
                                    d.next2   = 1'b1;
                                    d.mem_vld = 1'b0;
                                    d.st      = ST_ACK;
                                end else begin
                                    d.st = ST_SKIP;
                                end
                            end else if (|c7) begin
                                d.hit     = 1'b1;
                                d.id      = !c7[0];
                                d.wake    = 1'b1;
                                d.oe      = 1'b1;
                                d.next2   = 1'b0;
                                d.mem_vld = 1'b0;
                                d.st      = ST_ACK;
                            end else begin
                                d.st = ST_SKIP;
                            end
                        end else if (|clo) begin
                            d.hit     = 1'b1;
                            d.id      = !clo[0];
                            d.wake    = 1'b1;
                            d.oe      = 1'b1;
                            d.next2   = 1'b0;
                            d.mem_vld = 1'b1;
                            d.mem_id  = !clo[0];
                            d.st      = ST_ACK;
                        end else begin
                            d.st = ST_SKIP;
                        end
                    end
                end
                ST_ACK: begin
                    if (fall_i) begin
                        d.oe  = 1'b0;
                        d.cnt = '0;
                        d.st  = q.next2 ? ST_ADDR2 : ST_HOLD;
                    end
                end
                default: ;
            endcase
        end

        sda_oe_o = q.oe;
        hit_o    = q.hit;
        hit_id_o = q.id;
        hit_rw_o = q.rw;
        wake_o   = q.wake;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    // R2
    ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.oe && fall_i) |=> !q.oe);

    // R9
    wake_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.wake |-> q.hit);

    // R9
    wake_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.wake |=> !q.wake);

    // R7
    skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_SKIP) |-> !q.oe);

    // R11
    stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> !q.hit);

endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
    import i2c_am_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned PRE_W       = 8,
    parameter int unsigned TMO_W       = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic [ADDR_W-1:0] cfg_addr0,
    input  logic [ADDR_W-1:0] cfg_mask0,
    input  logic              cfg_ten0,
    input  logic [ADDR_W-1:0] cfg_addr1,
    input  logic [ADDR_W-1:0] cfg_mask1,
    input  logic              cfg_ten1,
    input  logic [PRE_W-1:0]  cfg_tick_div,
    input  logic [TMO_W-1:0]  cfg_tmo_limit,
    input  logic              tmo_clr_i,
    output logic              start_o,
    output logic              rstart_o,
    output logic              stop_o,
    output logic              addressed_o,
    output logic              hit_id_o,
    output logic              hit_rw_o,
    output logic              wake_o,
    output logic              tmo_o
);

    logic scl_lvl, sda_lvl, scl_rise, scl_fall;

    i2c_am_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_lvl_o  (scl_lvl),
        .sda_lvl_o  (sda_lvl),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_o),
        .rstart_o   (rstart_o),
        .stop_o     (stop_o)
    );

    i2c_am_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_o),
        .stop_i   (stop_o),
        .rise_i   (scl_rise),
        .fall_i   (scl_fall),
        .sda_i    (sda_lvl),
        .addr0_i  (cfg_addr0),
        .mask0_i  (cfg_mask0),
        .ten0_i   (cfg_ten0),
        .addr1_i  (cfg_addr1),
        .mask1_i  (cfg_mask1),
        .ten1_i   (cfg_ten1),
        .sda_oe_o (sda_oe_o),
        .hit_o    (addressed_o),
        .hit_id_o (hit_id_o),
        .hit_rw_o (hit_rw_o),
        .wake_o   (wake_o)
    );

    i2c_am_tmo #(.PRE_W(PRE_W), .TMO_W(TMO_W)) u_tmo (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_lvl_i  (scl_lvl),
        .scl_edge_i (scl_rise | scl_fall),
        .div_i      (cfg_tick_div),
        .limit_i    (cfg_tmo_limit),
        .clr_i      (tmo_clr_i),
        .flag_o     (tmo_o)
    );

endmodule

// File: tb/i2c_addr_match_tb.sv
module i2c_addr_match_tb;

    localparam int T = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_line;
    logic sda_oe;
    logic [9:0] a0 = '0, m0 = '0, a1 = '0, m1 = '0;
    logic t0 = 1'b0, t1 = 1'b0;
    logic [3:0] div = 4'd1;
    logic [9:0] lim = 10'd20;
    logic clr = 1'b0;
    logic start_p, rstart_p, stop_p, addressed, hid, hrw, wake, tmo;

    int nchk = 0;
    int nerr = 0;
    int wake_cnt = 0, start_cnt = 0, rstart_cnt = 0, stop_cnt = 0;

    always #2 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    i2c_addr_match #(.SYNC_STAGES(2), .PRE_W(4), .TMO_W(10)) u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe_o(sda_oe),
        .cfg_addr0(a0), .cfg_mask0(m0), .cfg_ten0(t0),
        .cfg_addr1(a1), .cfg_mask1(m1), .cfg_ten1(t1),
        .cfg_tick_div(div), .cfg_tmo_limit(lim), .tmo_clr_i(clr),
        .start_o(start_p), .rstart_o(rstart_p), .stop_o(stop_p),
        .addressed_o(addressed), .hit_id_o(hid), .hit_rw_o(hrw),
        .wake_o(wake), .tmo_o(tmo)
    );

    always @(posedge clk) begin
        if (wake)     wake_cnt++;
        if (start_p)  start_cnt++;
        if (rstart_p) rstart_cnt++;
        if (stop_p)   stop_cnt++;
    end

    // {address byte, expect ack, expect id, expect rw}
    localparam logic [10:0] VEC [6] = '{
        {8'h54, 1'b1, 1'b0, 1'b0},
        {8'h55, 1'b1, 1'b0, 1'b1},
        {8'h62, 1'b1, 1'b1, 1'b0},
        {8'h67, 1'b1, 1'b1, 1'b1},
        {8'h68, 1'b0, 1'b0, 1'b0},
        {8'h56, 1'b0, 1'b0, 1'b0}
    };

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; cyc(T);
        sda_m = 1'b0; cyc(T);
        scl_m = 1'b0; cyc(T);
    endtask

    task automatic bus_rstart();
        sda_m = 1'b1; cyc(T);
        scl_m = 1'b1; cyc(T);
        sda_m = 1'b0; cyc(T);
        scl_m = 1'b0; cyc(T);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; cyc(T);
        scl_m = 1'b1; cyc(T);
        sda_m = 1'b1; cyc(T);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; cyc(T);
            scl_m = 1'b1; cyc(T);
            scl_m = 1'b0; cyc(T);
        end
        sda_m = 1'b1; cyc(T);
        scl_m = 1'b1; cyc(T / 2);
        ack = ~sda_line;
        cyc(T / 2);
        scl_m = 1'b0; cyc(T);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        logic ack;
        int w0, s0, p0, r0;
        cyc(5);
        rst_n = 1'b1;
        cyc(5);
        // R12 reset state
        chk("R12 sda_oe", int'(sda_oe), 0);
        chk("R12 addressed", int'(addressed), 0);
        chk("R12 tmo", int'(tmo), 0);

        // 7-bit phase: slot0 0x2A exact, slot1 0x30 with low two bits masked
        a0 = 10'h02A; m0 = '0; t0 = 1'b0;
        a1 = 10'h030; m1 = 10'h003; t1 = 1'b0;
        cyc(4);
        for (int i = 0; i < 6; i++) begin
            logic [10:0] v;
            v = VEC[i];
            w0 = wake_cnt; s0 = start_cnt; p0 = stop_cnt;
            bus_start();
            send_byte(v[10:3], ack);
            chk("R2 R3 ack", int'(ack), int'(v[2]));
            chk("R2 addressed", int'(addressed), int'(v[2]));
            if (v[2]) begin
                chk("R2 R3 hit id", int'(hid), int'(v[1]));
                chk("R2 rw", int'(hrw), int'(v[0]));
            end
            chk("R9 wake count", wake_cnt - w0, int'(v[2]));
            bus_stop();
            cyc(4);
            chk("R11 addressed after stop", int'(addressed), 0);
            chk("R1 start pulses", start_cnt - s0, 1);
            chk("R1 stop pulses", stop_cnt - p0, 1);
        end

        // R7: mismatch, then a matching byte in the same transfer is ignored
        bus_start();
        send_byte(8'h68, ack);
        chk("R7 first byte ack", int'(ack), 0);
        send_byte(8'h54, ack);
        chk("R7 later byte ack", int'(ack), 0);
        chk("R7 addressed", int'(addressed), 0);
        bus_stop(); cyc(4);

        // R4: slot1 fully masked, both match 0x2A
        m1 = 10'h07F; cyc(4);
        bus_start();
        send_byte(8'h54, ack);
        chk("R4 ack", int'(ack), 1);
        chk("R4 priority id", int'(hid), 0);
        bus_stop(); cyc(4);
        bus_start();
        send_byte(8'h20, ack);
        chk("R4 slot1 only ack", int'(ack), 1);
        chk("R4 slot1 only id", int'(hid), 1);
        bus_stop(); cyc(4);

        // 10-bit phase: slot0 0x2A5, slot1 0x1C3
        a0 = 10'h2A5; m0 = '0; t0 = 1'b1;
        a1 = 10'h1C3; m1 = '0; t1 = 1'b1;
        cyc(4);
        w0 = wake_cnt; r0 = rstart_cnt;
        bus_start();
        send_byte(8'hF4, ack);
        chk("R5 header ack", int'(ack), 1);
        chk("R5 not yet addressed", int'(addressed), 0);
        send_byte(8'hA5, ack);
        chk("R5 low byte ack", int'(ack), 1);
        chk("R5 addressed", int'(addressed), 1);
        chk("R5 id", int'(hid), 0);
        chk("R5 rw", int'(hrw), 0);
        // R8 repeated start read header only
        bus_rstart();
        chk("R1 repeated start pulse", rstart_cnt - r0, 1);
        send_byte(8'hF5, ack);
        chk("R8 read header ack", int'(ack), 1);
        chk("R8 addressed", int'(addressed), 1);
        chk("R8 id", int'(hid), 0);
        chk("R8 rw", int'(hrw), 1);
        chk("R9 wake count 10-bit", wake_cnt - w0, 2);
        bus_stop(); cyc(4);

        bus_start();
        send_byte(8'hF2, ack);
        chk("R5 slot1 header ack", int'(ack), 1);
        send_byte(8'hC3, ack);
        chk("R5 slot1 low ack", int'(ack), 1);
        chk("R5 slot1 id", int'(hid), 1);
        bus_stop(); cyc(4);

        w0 = wake_cnt;
        bus_start();
        send_byte(8'hF4, ack);
        chk("R6 header ack", int'(ack), 1);
        send_byte(8'hA6, ack);
        chk("R6 low byte nack", int'(ack), 0);
        chk("R6 addressed", int'(addressed), 0);
        chk("R9 no wake on miss", wake_cnt - w0, 0);
        bus_stop(); cyc(4);

        // R10 time-out: divider 1, limit 20 ticks (about 40 cycles)
        chk("R10 no flag after traffic", int'(tmo), 0);
        scl_m = 1'b0; cyc(30);
        chk("R10 short low", int'(tmo), 0);
        scl_m = 1'b1; cyc(T);
        scl_m = 1'b0; cyc(30);
        chk("R10 restart on edge", int'(tmo), 0);
        cyc(40);
        chk("R10 flag set", int'(tmo), 1);
        scl_m = 1'b1; cyc(10);
        chk("R10 sticky", int'(tmo), 1);
        clr = 1'b1; cyc(1); clr = 1'b0; cyc(3);
        chk("R10 cleared", int'(tmo), 0);

        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

endmodule